// File: doc/BRIEF.md
# Smart Card Activation and Answer-To-Reset Sequencer

This block is the card-side controller of a contact smart card interface. It follows the supply, clock and reset levels seen at the card pads and steps through the activation states. Once reset is released with supply and clock present, it turns on the elementary-time-unit timer, reloads the default timing parameters and sends the stored Answer-To-Reset, one byte per valid/ready handshake, to a serial character engine.

After the last Answer-To-Reset byte, the block turns on only the receiver and waits for the reader. A first received byte of 0xFF hands control to the protocol-parameter negotiation logic. Any other first byte hands control to the command logic. Either one hands control back with a done strobe.

The stored Answer-To-Reset (up to 33 bytes) and its length are loaded through a simple write port. The character engine, the clock-ratio divider and the host link are outside this block. They are reached through enable, strobe and parameter ports.

Top module: `scard_act_seq`

## Requirements
- R1: Reset state. `card_state` reads 0. `uart_rx_en`, `uart_tx_en`, `etu_en`, `tx_valid` and both counters are 0. `fi`=1, `di`=1, `wi`=10, `wtime`=9600. The stored length is 4. State codes: 0 wait-power, 1 wait-clock, 2 wait-reset, 3 ATR-start, 4 sending-ATR, 5 in-negotiation, 6 wait-command, 7 in-command.
- R2: Power low and power rise.
  - While `card_pwr` is low, the next cycle shows state 0 with `etu_en` low, from any state. This wins over every other event in the same cycle.
  - A rise of `card_pwr` (sampled 0, now 1) while in state 0 moves to state 1.
- R3: In state 1, `card_clk_on` high moves to state 2 in the next cycle.
- R4: Reset release and reset hold.
  - A reset release starts an ATR when `card_rst_on` was 1 in the previous cycle (taken as 1 after `rst`), is 0 now, and `card_pwr` and `card_clk_on` are both high. The next cycle then shows state 3 with `etu_en` high.
  - A release while the clock is off does nothing.
  - `card_rst_on` high clears `etu_en` and leaves the state unchanged.
- R5: In state 3, `fi`=1, `di`=1, `wi`=10, `wtime`=9600, `uart_tx_en`=1 and `uart_rx_en`=0. This holds even when a negotiation changed `fi` and `di` earlier.
- R6: ATR transmission.
  - In state 4 the stored bytes are offered from index 0 upward on `tx_data` with `tx_valid` high.
  - Each byte is held stable until `tx_ready` is seen high at a clock edge.
  - After the last byte is accepted, the state is 6.
- R7: In states 0, 1 and 2, `uart_rx_en` and `uart_tx_en` are both 0. In state 6, `uart_rx_en`=1 and `uart_tx_en`=0.
- R8: Received bytes and hand-back.
  - A byte received in states 0 to 4 leaves the state unchanged.
  - In state 6, byte 0xFF moves to state 5 and pulses `pps_start` in the same cycle. Any other byte moves to state 7 and pulses `tpdu_start`.
  - `xchg_done` in state 5 or 7 returns to state 6.
- R9: Stored ATR and length writes.
  - The stored ATR defaults to 3B 02 14 50. A byte write to an address below 33 replaces that entry.
  - A length write above 33 sets `atr_len_err` and keeps the old length. A valid length write clears the error.
- R10: `ratio_wr` loads `fi`/`di` only in state 5. In every other state it is ignored.
- R11: `rx_count` counts every `rx_valid` cycle. `tx_count` counts every accepted ATR handshake, including one accepted in the same cycle as a power loss.
- R12: With a stored length of 0, state 3 moves straight to state 6 and no byte is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| card_pwr | input | 1 | Card supply present |
| card_clk_on | input | 1 | Card clock running |
| card_rst_on | input | 1 | Card reset asserted |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| xchg_done | input | 1 | Negotiation/command logic finished |
| ratio_wr | input | 1 | Load negotiated clock ratio |
| ratio_fi | input | 4 | Negotiated rate-conversion index |
| ratio_di | input | 4 | Negotiated rate-adjustment index |
| atr_wr_en | input | 1 | Stored ATR byte write |
| atr_wr_addr | input | ADDR_W | Byte write address |
| atr_wr_data | input | 8 | Byte write data |
| atr_len_we | input | 1 | Stored length write |
| atr_len_val | input | ADDR_W | Length write value |
| tx_ready | input | 1 | Character engine accepts byte |
| tx_valid | output | 1 | ATR byte offered |
| tx_data | output | 8 | ATR byte |
| uart_rx_en | output | 1 | Receiver enable |
| uart_tx_en | output | 1 | Transmitter enable |
| etu_en | output | 1 | Elementary-time-unit timer enable |
| fi | output | 4 | Rate-conversion index |
| di | output | 4 | Rate-adjustment index |
| wi | output | 8 | Waiting integer |
| wtime | output | 16 | Waiting time in clocks |
| card_state | output | 3 | Sequencer state code |
| pps_start | output | 1 | Negotiation begins |
| tpdu_start | output | 1 | Command begins |
| atr_len_err | output | 1 | Last length write rejected |
| rx_count | output | CNT_W | Received byte count |
| tx_count | output | CNT_W | Sent ATR byte count |

## Verification
Two functions can meet in one cycle: acceptance of the final ATR byte and a supply loss. The bench provokes this by dropping `card_pwr` in the cycle where the last byte's handshake completes. The state must land in wait-power with every enable and the timer off, and the byte must still be counted and checked by the scoreboard. A second pairing is a negotiated clock ratio written in one ATR pass, followed by a reset release. The next ATR start must show the reloaded defaults rather than the negotiated values.

// File: rtl/scard_act_pkg.sv
package scard_act_pkg;

    localparam int FI_W = 4;
    localparam int WI_W = 8;
    localparam int WT_W = 16;

    localparam logic [FI_W-1:0] DEF_FI    = 4'd1;
    localparam logic [FI_W-1:0] DEF_DI    = 4'd1;
    localparam logic [WI_W-1:0] DEF_WI    = 8'd10;
    localparam logic [WT_W-1:0] DEF_WTIME = 16'd9600;
    localparam int              DEF_LEN   = 4;
    localparam logic [7:0]      NEG_LEAD  = 8'hFF;

    typedef enum logic [2:0] {
        ST_PWR   = 3'd0,
        ST_CLK   = 3'd1,
        ST_RSTW  = 3'd2,
        ST_ATR0  = 3'd3,
        ST_ATR   = 3'd4,
        ST_NEG   = 3'd5,
        ST_WCMD  = 3'd6,
        ST_CMD   = 3'd7
    } card_st_e;

    typedef struct packed {
        logic pwr_off;
        logic pwr_on;
        logic clk_on;
        logic rst_rel;
        logic rst_hold;
    } pad_ev_t;

    typedef struct packed {
        logic [FI_W-1:0] fi;
        logic [FI_W-1:0] di;
        logic [WI_W-1:0] wi;
        logic [WT_W-1:0] wtime;
    } timing_t;

    function automatic logic [7:0] default_atr_byte(input int unsigned i);
        case (i)
            0:       return 8'h3B;
            1:       return 8'h02;
            2:       return 8'h14;
            3:       return 8'h50;
            default: return 8'h00;
        endcase
    endfunction

    function automatic timing_t default_timing();
        timing_t t;
        t.fi    = DEF_FI;
        t.di    = DEF_DI;
        t.wi    = DEF_WI;
        t.wtime = DEF_WTIME;
        return t;
    endfunction

    function automatic logic is_pre_atr(input card_st_e s);
        return (s == ST_PWR) || (s == ST_CLK) || (s == ST_RSTW);
    endfunction

endpackage

// File: rtl/scard_pad_track.sv
module scard_pad_track
    import scard_act_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    card_pwr,
    input  logic    card_clk_on,
    input  logic    card_rst_on,
    output pad_ev_t ev
);

    logic pwr_q;
    logic rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= 1'b0;
            rst_q <= 1'b1;
        end else begin
            pwr_q <= card_pwr;
            rst_q <= card_rst_on;
        end
    end

    always_comb begin
        ev.pwr_off  = !card_pwr;
        ev.pwr_on   = card_pwr && !pwr_q;
        ev.clk_on   = card_clk_on;
        ev.rst_rel  = rst_q && !card_rst_on && card_pwr && card_clk_on;
        ev.rst_hold = card_rst_on;
    end

endmodule

// File: rtl/scard_atr_store.sv
module scard_atr_store
    import scard_act_pkg::*;
#(
    parameter int ATR_MAX = 33,
    localparam int ADDR_W = $clog2(ATR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              len_we,
    input  logic [ADDR_W-1:0] len_val,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] len,
    output logic              len_err
);

    localparam logic [ADDR_W-1:0] MAX_A = ADDR_W'(ATR_MAX);

    logic [7:0] mem [ATR_MAX];

    for (genvar g = 0; g < ATR_MAX; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= default_atr_byte(g);
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len     <= ADDR_W'(DEF_LEN);
            len_err <= 1'b0;
        end else if (len_we) begin
            if (len_val > MAX_A) begin
                len_err <= 1'b1;
            end else begin
                len     <= len_val;
                len_err <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        if (rd_idx < MAX_A) begin
            rd_byte = mem[rd_idx];
        end
    end

    AST_LEN_REJECT: assert property (@(posedge clk) disable iff (rst)
        (len_we && (len_val > MAX_A)) |=> (len_err && $stable(len))); // R9

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        len <= MAX_A); // R9

endmodule

// File: rtl/scard_byte_cnt.sv
module scard_byte_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/scard_seq_ctrl.sv
module scard_seq_ctrl
    import scard_act_pkg::*;
#(
    parameter int ATR_MAX = 33,
    localparam int ADDR_W = $clog2(ATR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  pad_ev_t           ev,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              xchg_done,
    input  logic              ratio_wr,
    input  logic [FI_W-1:0]   ratio_fi,
    input  logic [FI_W-1:0]   ratio_di,
    input  logic              tx_ready,
    input  logic [ADDR_W-1:0] atr_len,
    input  logic [7:0]        atr_byte,
    output logic [ADDR_W-1:0] rd_idx,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_fire,
    output logic              rx_en,
    output logic              tx_en,
    output logic              etu_en,
    output timing_t           timing,
    output card_st_e          st,
    output logic              pps_start,
    output logic              tpdu_start
);

    card_st_e          nxt;
    logic [ADDR_W-1:0] idx;
    logic              enter_atr;
    logic              last_byte;

    assign enter_atr = !ev.pwr_off && ev.rst_rel;
    assign tx_valid  = (st == ST_ATR);
    assign tx_data   = atr_byte;
    assign tx_fire   = tx_valid && tx_ready;
    assign rd_idx    = idx;
    assign last_byte = ((idx + ADDR_W'(1)) >= atr_len);

    always_comb begin
        nxt = st;
        if (ev.pwr_off) begin
            nxt = ST_PWR;
        end else if (ev.rst_rel) begin
            nxt = ST_ATR0;
        end else begin
            unique case (st)
                ST_PWR:  if (ev.pwr_on) nxt = ST_CLK;
                ST_CLK:  if (ev.clk_on) nxt = ST_RSTW;
                ST_RSTW: nxt = ST_RSTW;
                ST_ATR0: nxt = (atr_len == '0) ? ST_WCMD : ST_ATR;
                ST_ATR:  if (tx_fire && last_byte) nxt = ST_WCMD;
                ST_NEG,
                ST_CMD:  if (xchg_done) nxt = ST_WCMD;
                ST_WCMD: if (rx_valid) nxt = (rx_data == NEG_LEAD) ? ST_NEG : ST_CMD;
            endcase
        end
    end

    assign pps_start  = (st == ST_WCMD) && (nxt == ST_NEG);
    assign tpdu_start = (st == ST_WCMD) && (nxt == ST_CMD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_PWR;
        end else begin
            st <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (enter_atr) begin
            idx <= '0;
        end else if (tx_fire) begin
            idx <= idx + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timing <= default_timing();
        end else if (enter_atr) begin
            timing <= default_timing();
        end else if (ratio_wr && (st == ST_NEG)) begin
            timing.fi <= ratio_fi;
            timing.di <= ratio_di;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            etu_en <= 1'b0;
        end else if (ev.pwr_off) begin
            etu_en <= 1'b0;
        end else if (enter_atr) begin
            etu_en <= 1'b1;
        end else if (ev.rst_hold) begin
            etu_en <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
        end else begin
            unique case (nxt)
                ST_PWR, ST_CLK, ST_RSTW: begin
                    rx_en <= 1'b0;
                    tx_en <= 1'b0;
                end
                ST_ATR0: begin
                    rx_en <= 1'b0;
                    tx_en <= 1'b1;
                end
                ST_WCMD: begin
                    rx_en <= 1'b1;
                    tx_en <= 1'b0;
                end
                default: begin
                    rx_en <= rx_en;
                    tx_en <= tx_en;
                end
            endcase
        end
    end

    AST_PWR_LOSS: assert property (@(posedge clk) disable iff (rst)
        ev.pwr_off |=> (st == ST_PWR && !etu_en && !rx_en && !tx_en)); // R2

    AST_PRE_ATR_SILENT: assert property (@(posedge clk) disable iff (rst)
        is_pre_atr(st) |-> (!rx_en && !tx_en)); // R7

    AST_ATR_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ATR0) |-> (timing.fi == DEF_FI && timing.di == DEF_DI &&
                             timing.wi == DEF_WI && timing.wtime == DEF_WTIME &&
                             tx_en && !rx_en)); // R5

    AST_ETU_START: assert property (@(posedge clk) disable iff (rst)
        $rose(etu_en) |-> (st == ST_ATR0)); // R4

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !ev.pwr_off && !ev.rst_rel) |=> (tx_valid && $stable(tx_data))); // R6

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
        !(pps_start && tpdu_start)); // R8

endmodule

// File: rtl/scard_act_seq.sv
module scard_act_seq
    import scard_act_pkg::*;
#(
    parameter int ATR_MAX = 33,
    parameter int CNT_W   = 16,
    localparam int ADDR_W = $clog2(ATR_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              card_pwr,
    input  logic              card_clk_on,
    input  logic              card_rst_on,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              xchg_done,
    input  logic              ratio_wr,
    input  logic [3:0]        ratio_fi,
    input  logic [3:0]        ratio_di,
    input  logic              atr_wr_en,
    input  logic [ADDR_W-1:0] atr_wr_addr,
    input  logic [7:0]        atr_wr_data,
    input  logic              atr_len_we,
    input  logic [ADDR_W-1:0] atr_len_val,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              uart_rx_en,
    output logic              uart_tx_en,
    output logic              etu_en,
    output logic [3:0]        fi,
    output logic [3:0]        di,
    output logic [7:0]        wi,
    output logic [15:0]       wtime,
    output logic [2:0]        card_state,
    output logic              pps_start,
    output logic              tpdu_start,
    output logic              atr_len_err,
    output logic [CNT_W-1:0]  rx_count,
    output logic [CNT_W-1:0]  tx_count
);

    pad_ev_t           ev;
    timing_t           timing;
    card_st_e          st;
    logic [ADDR_W-1:0] rd_idx;
    logic [ADDR_W-1:0] atr_len;
    logic [7:0]        atr_byte;
    logic              tx_fire;

    scard_pad_track u_pads (
        .clk         (clk),
        .rst         (rst),
        .card_pwr    (card_pwr),
        .card_clk_on (card_clk_on),
        .card_rst_on (card_rst_on),
        .ev          (ev)
    );

    scard_atr_store #(.ATR_MAX(ATR_MAX)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (atr_wr_en),
        .wr_addr (atr_wr_addr),
        .wr_data (atr_wr_data),
        .len_we  (atr_len_we),
        .len_val (atr_len_val),
        .rd_idx  (rd_idx),
        .rd_byte (atr_byte),
        .len     (atr_len),
        .len_err (atr_len_err)
    );

    scard_seq_ctrl #(.ATR_MAX(ATR_MAX)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .xchg_done  (xchg_done),
        .ratio_wr   (ratio_wr),
        .ratio_fi   (ratio_fi),
        .ratio_di   (ratio_di),
        .tx_ready   (tx_ready),
        .atr_len    (atr_len),
        .atr_byte   (atr_byte),
        .rd_idx     (rd_idx),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_fire    (tx_fire),
        .rx_en      (uart_rx_en),
        .tx_en      (uart_tx_en),
        .etu_en     (etu_en),
        .timing     (timing),
        .st         (st),
        .pps_start  (pps_start),
        .tpdu_start (tpdu_start)
    );

    scard_byte_cnt #(.W(CNT_W)) u_rx_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (rx_valid),
        .count (rx_count)
    );

    scard_byte_cnt #(.W(CNT_W)) u_tx_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (tx_fire),
        .count (tx_count)
    );

    assign fi         = timing.fi;
    assign di         = timing.di;
    assign wi         = timing.wi;
    assign wtime      = timing.wtime;
    assign card_state = st;

endmodule

// File: tb/scard_act_seq_tb.sv
module scard_act_seq_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        card_pwr = 1'b0, card_clk_on = 1'b0, card_rst_on = 1'b1;
    logic        rx_valid = 1'b0, xchg_done = 1'b0, ratio_wr = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [3:0]  ratio_fi = 4'd0, ratio_di = 4'd0;
    logic        atr_wr_en = 1'b0, atr_len_we = 1'b0, tx_ready = 1'b0;
    logic [5:0]  atr_wr_addr = '0, atr_len_val = '0;
    logic [7:0]  atr_wr_data = 8'h00;
    logic        tx_valid, uart_rx_en, uart_tx_en, etu_en, pps_start, tpdu_start, atr_len_err;
    logic [7:0]  tx_data, wi;
    logic [3:0]  fi, di;
    logic [15:0] wtime, rx_count, tx_count;
    logic [2:0]  card_state;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    scard_act_seq u_dut (
        .clk(clk), .rst(rst), .card_pwr(card_pwr), .card_clk_on(card_clk_on),
        .card_rst_on(card_rst_on), .rx_valid(rx_valid), .rx_data(rx_data),
        .xchg_done(xchg_done), .ratio_wr(ratio_wr), .ratio_fi(ratio_fi),
        .ratio_di(ratio_di), .atr_wr_en(atr_wr_en), .atr_wr_addr(atr_wr_addr),
        .atr_wr_data(atr_wr_data), .atr_len_we(atr_len_we), .atr_len_val(atr_len_val),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .uart_rx_en(uart_rx_en), .uart_tx_en(uart_tx_en), .etu_en(etu_en),
        .fi(fi), .di(di), .wi(wi), .wtime(wtime), .card_state(card_state),
        .pps_start(pps_start), .tpdu_start(tpdu_start), .atr_len_err(atr_len_err),
        .rx_count(rx_count), .tx_count(tx_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_expected(input logic [7:0] b);
        sb_q.push_back(b);
    endtask

    task automatic write_byte(input logic [5:0] a, input logic [7:0] d);
        atr_wr_en = 1'b1; atr_wr_addr = a; atr_wr_data = d;
        tick();
        atr_wr_en = 1'b0;
    endtask

    task automatic write_len(input logic [5:0] v);
        atr_len_we = 1'b1; atr_len_val = v;
        tick();
        atr_len_we = 1'b0;
    endtask

    task automatic wait_state(input logic [2:0] s, input string req);
        int n = 0;
        while (card_state !== s && n < 200) begin
            tick();
            n++;
        end
        check(req, card_state, s);
    endtask

    // scoreboard monitor: every accepted ATR byte is popped and compared (R6)
    always @(negedge clk) begin
        if (!rst && tx_valid && tx_ready) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R6 unexpected byte actual=%0h expected=none", tx_data);
            end else begin
                logic [7:0] e;
                e = sb_q.pop_front();
                if (tx_data !== e) begin
                    errors++;
                    $display("FAIL R6 ATR byte actual=%0h expected=%0h", tx_data, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 state", card_state, 0);
        check("R1 enables", {uart_rx_en, uart_tx_en, etu_en, tx_valid}, 0);
        check("R1 counters", {rx_count, tx_count}, 0);
        check("R1 timing", {fi, di, wi, wtime}, {4'd1, 4'd1, 8'd10, 16'd9600});

        // R8 byte ignored before ATR
        rx_valid = 1'b1; rx_data = 8'h00; tick(); rx_valid = 1'b0;
        check("R8 ignored in wait-power", card_state, 0);

        card_pwr = 1'b1; tick();
        check("R2 power rise", card_state, 1);
        card_clk_on = 1'b1; tick();
        check("R3 clock on", card_state, 2);
        check("R7 silent pre-ATR", {uart_rx_en, uart_tx_en}, 0);
        rx_valid = 1'b1; rx_data = 8'hFF; tick(); rx_valid = 1'b0;
        check("R8 ignored in wait-reset", card_state, 2);

        // first ATR with default content and a stalled consumer
        push_expected(8'h3B); push_expected(8'h02); push_expected(8'h14); push_expected(8'h50);
        card_rst_on = 1'b0; tick();
        check("R4 release state", card_state, 3);
        check("R4 timer on", etu_en, 1);
        check("R5 tx only", {uart_tx_en, uart_rx_en}, 2'b10);
        tick();
        check("R6 first byte offered", {tx_valid, tx_data}, {1'b1, 8'h3B});
        tick(); tick();
        check("R6 byte held under stall", {tx_valid, tx_data}, {1'b1, 8'h3B});
        tx_ready = 1'b1;
        wait_state(3'd6, "R6 end of ATR");
        check("R6 scoreboard drained", sb_q.size(), 0);
        check("R7 rx only", {uart_rx_en, uart_tx_en}, 2'b10);
        check("R11 tx count", tx_count, 4);

        // R10 ratio write ignored outside negotiation
        ratio_wr = 1'b1; ratio_fi = 4'd9; ratio_di = 4'd3; tick(); ratio_wr = 1'b0;
        check("R10 ignored in wait-command", {fi, di}, {4'd1, 4'd1});

        rx_valid = 1'b1; rx_data = 8'hA0; #1;
        check("R8 tpdu_start pulse", {tpdu_start, pps_start}, 2'b10);
        tick(); rx_valid = 1'b0;
        check("R8 command state", card_state, 7);
        xchg_done = 1'b1; tick(); xchg_done = 1'b0;
        check("R8 hand back", card_state, 6);
        rx_valid = 1'b1; rx_data = 8'hFF; #1;
        check("R8 pps_start pulse", {tpdu_start, pps_start}, 2'b01);
        tick(); rx_valid = 1'b0;
        check("R8 negotiation state", card_state, 5);
        check("R11 rx count", rx_count, 4);
        ratio_wr = 1'b1; tick(); ratio_wr = 1'b0;
        check("R10 ratio loaded", {fi, di}, {4'd9, 4'd3});

        // R9 store programming
        write_len(6'd40);
        check("R9 length rejected", atr_len_err, 1);
        write_byte(6'd1, 8'h11);
        write_byte(6'd2, 8'h22);
        write_len(6'd3);
        check("R9 error cleared", atr_len_err, 0);
        push_expected(8'h3B); push_expected(8'h11); push_expected(8'h22);
        card_rst_on = 1'b1; tick();
        check("R4 reset hold timer off", etu_en, 0);
        check("R4 reset hold state kept", card_state, 5);
        card_rst_on = 1'b0; tick();
        check("R5 defaults reloaded", {card_state, fi, di, wi, wtime},
              {3'd3, 4'd1, 4'd1, 8'd10, 16'd9600});
        wait_state(3'd6, "R9 new ATR length");
        check("R9 scoreboard drained", sb_q.size(), 0);
        check("R11 tx count second", tx_count, 7);

        // power loss in the cycle of the last handshake
        push_expected(8'h3B); push_expected(8'h11); push_expected(8'h22);
        card_rst_on = 1'b1; tick();
        card_rst_on = 1'b0; tick();
        tick();
        tick(); tick();
        card_pwr = 1'b0; tick();
        check("R2 power loss wins", card_state, 0);
        check("R2 outputs off", {etu_en, uart_rx_en, uart_tx_en}, 0);
        check("R11 last byte counted", tx_count, 10);
        check("R6 scoreboard drained third", sb_q.size(), 0);

        // R12 empty ATR
        write_len(6'd0);
        card_pwr = 1'b1; tick();
        tick();
        check("R12 reached wait-reset", card_state, 2);
        card_rst_on = 1'b1; tick();
        card_rst_on = 1'b0; tick();
        check("R12 start state", {card_state, tx_valid}, {3'd3, 1'b0});
        tick();
        check("R12 no bytes", {card_state, tx_valid}, {3'd6, 1'b0});
        check("R12 tx count unchanged", tx_count, 10);

        // R4 release without clock
        card_clk_on = 1'b0;
        card_rst_on = 1'b1; tick();
        card_rst_on = 1'b0; tick();
        check("R4 no start without clock", {card_state, etu_en}, {3'd6, 1'b0});

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule